// File: doc/BRIEF.md
# Multi-mode barrel shift slice

This block is the shift portion of a processor execution stage. Its data path is combinational. It offers three shifts on 32-bit words: an arithmetic shift to the right, a logical shift to the left, and a funnel shift. The funnel shift joins a high word and a low word into one 64-bit value, shifts that value left, and returns its upper half.

The shift distance comes from one of two places. It is either the low five bits of a register operand or a 5-bit immediate field, and a select input picks which. The two ordinary shifts produce carry, overflow, sign and zero flags. These flags are captured in registers on the clock edge whenever a valid operation writes them. The funnel shift and the reserved operation code leave the flag registers alone.

Top module: `shift_slice`

## Requirements
- R1: With `imm_sel` low the distance is `amt_reg[4:0]` and bits 31..5 of `amt_reg` have no effect. With `imm_sel` high the distance is `amt_imm`, zero-extended, and `amt_reg` has no effect.
- R2: With `op` = 2'b00 the result is `opa_lo` shifted right by the distance, and every vacated upper bit is filled with a copy of `opa_lo[31]`.
- R3: With `op` = 2'b01 the result is `opa_lo` shifted left by the distance, and the vacated low bits are zero.
- R4: With `op` = 2'b10 the result is bits 63..32 of the 64-bit value {`opa_hi`,`opa_lo`} shifted left logically by the distance.
- R5: A funnel shift by a distance of 0 returns `opa_hi` unchanged.
- R6: After a valid shift with `op` 2'b00 or 2'b01, `cy` holds the last bit shifted out. It is 0 when the distance is 0.
- R7: After a valid shift with `op` 2'b00 or 2'b01, `ov` is 0.
- R8: After a valid shift with `op` 2'b00 or 2'b01, `sgn` equals bit 31 of that result. `zf` is 1 exactly when all 32 result bits are zero.
- R9: A valid operation with `op` 2'b10 or 2'b11 leaves all four flags unchanged. With `op` 2'b11 the result is `opa_lo` unchanged.
- R10: The flags change only at a rising clock edge with `in_valid` high. An active-low reset clears all four flags to 0.
- R11: `flag_we` is high exactly when `in_valid` is high and `op` is 2'b00 or 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | 00 arithmetic right, 01 logical left, 10 funnel left, 11 reserved |
| opa_lo | input | 32 | Shifted word; low half in funnel mode |
| opa_hi | input | 32 | High half in funnel mode |
| amt_reg | input | 32 | Register source of the distance (bits 4..0 used) |
| amt_imm | input | 5 | Immediate distance |
| imm_sel | input | 1 | 1 selects the immediate distance |
| result | output | 32 | Combinational shift result |
| flag_we | output | 1 | Flags are written at the next edge |
| cy | output | 1 | Registered carry flag |
| ov | output | 1 | Registered overflow flag |
| sgn | output | 1 | Registered sign flag |
| zf | output | 1 | Registered zero flag |

## Verification
The hardest case to reach from the ports is a funnel shift that must leave flags unchanged. It only shows anything when the flags already hold values that a correct funnel result would overwrite. The stimulus therefore runs a shift that leaves carry, sign or zero set. It then runs a funnel shift whose own result would give different flag values, and checks that the flags did not move. Each mode is also swept over all 32 distances with random operands. The source of the distance is also toggled while the unused source carries values that would change the result.

// File: rtl/shift_slice_pkg.sv
package shift_slice_pkg;
   typedef enum logic [1:0] {
      SOP_SRA    = 2'b00,
      SOP_SLL    = 2'b01,
      SOP_FUNNEL = 2'b10,
      SOP_RSVD   = 2'b11
   } shift_op_e;

   typedef struct packed {
      logic cy;
      logic ov;
      logic sgn;
      logic zf;
   } shift_flags_t;
endpackage

// File: rtl/shift_amt_sel.sv
module shift_amt_sel #(
   parameter int REG_W = 32,
   parameter int IMM_W = 5,
   parameter int SHW   = 5
) (
   input  logic [REG_W-1:0] amt_reg,
   input  logic [IMM_W-1:0] amt_imm,
   input  logic             imm_sel,
   output logic [SHW-1:0]   amt
);
   generate
      if (IMM_W > SHW) begin : g_bad_imm
         $error("shift_amt_sel: immediate wider than shift field");
      end
      if (SHW > REG_W) begin : g_bad_reg
         $error("shift_amt_sel: register narrower than shift field");
      end
   endgenerate

   logic [SHW-1:0] imm_ext;
   logic [SHW-1:0] reg_cut;

   generate
      if (IMM_W == SHW) begin : g_imm_same
         assign imm_ext = amt_imm;
      end else begin : g_imm_pad
         assign imm_ext = {{(SHW-IMM_W){1'b0}}, amt_imm};
      end
   endgenerate

   assign reg_cut = amt_reg[SHW-1:0];
   assign amt     = imm_sel ? imm_ext : reg_cut;
endmodule

// File: rtl/shift_barrel.sv
module shift_barrel #(
   parameter int W     = 64,
   parameter int SHW   = 5,
   parameter bit LEFT  = 1'b1,
   parameter bit ARITH = 1'b0
) (
   input  logic [W-1:0]   din,
   input  logic [SHW-1:0] amt,
   output logic [W-1:0]   dout
);
   generate
      if ((1 << (SHW-1)) >= W) begin : g_bad_w
         $error("shift_barrel: stage step exceeds width");
      end
   endgenerate

   logic [W-1:0] stage [SHW+1];
   assign stage[0] = din;

   for (genvar i = 0; i < SHW; i++) begin : g_stage
      localparam int STEP = 1 << i;
      logic [W-1:0] moved;
      if (LEFT) begin : g_left
         assign moved = {stage[i][W-1-STEP:0], {STEP{1'b0}}};
      end else if (ARITH) begin : g_rarith
         assign moved = {{STEP{stage[i][W-1]}}, stage[i][W-1:STEP]};
      end else begin : g_rlog
         assign moved = {{STEP{1'b0}}, stage[i][W-1:STEP]};
      end
      assign stage[i+1] = amt[i] ? moved : stage[i];
   end

   assign dout = stage[SHW];
endmodule

// File: rtl/shift_flag_gen.sv
module shift_flag_gen
   import shift_slice_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  shift_op_e          op,
   input  logic               in_valid,
   input  logic [DATA_W-1:0]  res,
   input  logic               cy_left,
   input  logic               cy_right,
   output shift_flags_t       nxt,
   output logic               we
);
   logic is_shift;

   always_comb begin
      is_shift = (op == SOP_SRA) || (op == SOP_SLL);
      we       = in_valid && is_shift;
      nxt.cy   = (op == SOP_SRA) ? cy_right : cy_left;
      nxt.ov   = 1'b0;
      nxt.sgn  = res[DATA_W-1];
      nxt.zf   = (res == '0);
   end
endmodule

// File: rtl/shift_slice.sv
module shift_slice
   import shift_slice_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] opa_lo,
   input  logic [DATA_W-1:0] opa_hi,
   input  logic [DATA_W-1:0] amt_reg,
   input  logic [IMM_W-1:0]  amt_imm,
   input  logic              imm_sel,
   output logic [DATA_W-1:0] result,
   output logic              flag_we,
   output logic              cy,
   output logic              ov,
   output logic              sgn,
   output logic              zf
);
   localparam int SHW  = $clog2(DATA_W);
   localparam int LW   = 2 * DATA_W;
   localparam int RW   = DATA_W + 1;

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_dw
         $error("shift_slice: DATA_W must be a power of two, at least 8");
      end
   endgenerate

   shift_op_e      op_e;
   logic [SHW-1:0] amt;
   logic [LW-1:0]  l_in, l_out;
   logic [RW-1:0]  r_in, r_out;
   shift_flags_t   f_nxt, f_q;

   assign op_e = shift_op_e'(op);

   shift_amt_sel #(.REG_W(DATA_W), .IMM_W(IMM_W), .SHW(SHW)) u_amt (
      .amt_reg (amt_reg),
      .amt_imm (amt_imm),
      .imm_sel (imm_sel),
      .amt     (amt)
   );

   assign l_in = (op_e == SOP_FUNNEL) ? {opa_hi, opa_lo} : {{DATA_W{1'b0}}, opa_lo};
   assign r_in = {opa_lo, 1'b0};

   shift_barrel #(.W(LW), .SHW(SHW), .LEFT(1'b1), .ARITH(1'b0)) u_left (
      .din  (l_in),
      .amt  (amt),
      .dout (l_out)
   );

   shift_barrel #(.W(RW), .SHW(SHW), .LEFT(1'b0), .ARITH(1'b1)) u_right (
      .din  (r_in),
      .amt  (amt),
      .dout (r_out)
   );

   always_comb begin
      unique case (op_e)
         SOP_SRA:    result = r_out[RW-1:1];
         SOP_SLL:    result = l_out[DATA_W-1:0];
         SOP_FUNNEL: result = l_out[LW-1:DATA_W];
         default:    result = opa_lo;
      endcase
   end

   shift_flag_gen #(.DATA_W(DATA_W)) u_flags (
      .op       (op_e),
      .in_valid (in_valid),
      .res      (result),
      .cy_left  (l_out[DATA_W]),
      .cy_right (r_out[0]),
      .nxt      (f_nxt),
      .we       (flag_we)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_q <= '0;
      end else if (flag_we) begin
         f_q <= f_nxt;
      end
   end

   assign cy  = f_q.cy;
   assign ov  = f_q.ov;
   assign sgn = f_q.sgn;
   assign zf  = f_q.zf;

   logic is_sh;
   assign is_sh = (op == 2'b00) || (op == 2'b01);

   assert_funnel_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 2'b10 && amt == '0) |-> (result == opa_hi));

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_sh) |=> !ov);

   assert_zero_amt_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_sh && amt == '0) |=> !cy);

   assert_sign_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_sh) |=> (sgn == $past(result[DATA_W-1])));

   assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid || !is_sh) |=> ($stable(cy) && $stable(ov) && $stable(sgn) && $stable(zf)));

   assert_we_decode_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> (in_valid && (op[1] == 1'b0)));
endmodule

// File: tb/shift_slice_tb.sv
module shift_slice_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [31:0] opa_lo = '0, opa_hi = '0, amt_reg = '0;
   logic [4:0]  amt_imm = '0;
   logic        imm_sel = 1'b0;
   logic [31:0] result;
   logic        flag_we, cy, ov, sgn, zf;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [3:0] mflags = 4'b0000; // {cy,ov,sgn,zf} expected

   always #5 clk = ~clk;

   shift_slice u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .opa_lo(opa_lo), .opa_hi(opa_hi), .amt_reg(amt_reg),
      .amt_imm(amt_imm), .imm_sel(imm_sel), .result(result),
      .flag_we(flag_we), .cy(cy), .ov(ov), .sgn(sgn), .zf(zf)
   );

   localparam int NV = 8;
   localparam logic [1:0]  T_OP  [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b01, 2'b11};
   localparam logic [31:0] T_LO  [NV] = '{32'h80000000, 32'h0000000F, 32'h00000001, 32'hC0000000,
                                          32'h9ABCDEF0, 32'h9ABCDEF0, 32'h80000000, 32'h13572468};
   localparam logic [31:0] T_HI  [NV] = '{32'h0, 32'h0, 32'h0, 32'h0,
                                          32'h12345678, 32'h12345678, 32'h0, 32'hFFFFFFFF};
   localparam logic [31:0] T_AMT [NV] = '{32'd4, 32'd1, 32'd31, 32'd1, 32'd8, 32'hFFFFFFE0, 32'd1, 32'd9};
   localparam logic [31:0] T_EXP [NV] = '{32'hF8000000, 32'h00000007, 32'h80000000, 32'h80000000,
                                          32'h3456789A, 32'h12345678, 32'h00000000, 32'h13572468};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [32:0] model(input logic [1:0] o, input logic [31:0] lo,
                                          input logic [31:0] hi, input int n);
      logic [63:0] w;
      logic [31:0] r;
      logic        c;
      c = 1'b0;
      case (o)
         2'b00: begin r = 32'($signed(lo) >>> n); if (n > 0) c = lo[n-1]; end
         2'b01: begin r = lo << n; if (n > 0) c = lo[32-n]; end
         2'b10: begin w = {hi, lo} << n; r = w[63:32]; end
         default: r = lo;
      endcase
      return {c, r};
   endfunction

   task automatic run(input logic [1:0] o, input logic [31:0] lo, input logic [31:0] hi,
                      input logic [31:0] ar, input logic [4:0] ai, input logic is,
                      input string req);
      logic [32:0] m;
      int n;
      @(negedge clk);
      in_valid = 1'b1; op = o; opa_lo = lo; opa_hi = hi;
      amt_reg = ar; amt_imm = ai; imm_sel = is;
      n = is ? int'(ai) : int'(ar[4:0]);
      m = model(o, lo, hi, n);
      #1;
      chk({req, " result"}, result, m[31:0]);
      chk("R11 flag_we", {31'b0, flag_we}, {31'b0, (o[1] == 1'b0)});
      if (o[1] == 1'b0) mflags = {m[32], 1'b0, m[31], (m[31:0] == 32'b0)};
      @(posedge clk); #1;
      chk({req, " flags R6 R7 R8 R9"}, {28'b0, cy, ov, sgn, zf}, {28'b0, mflags});
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] a, b, junk;
      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset flags", {28'b0, cy, ov, sgn, zf}, 32'b0);
      rst_n = 1'b1;

      // table of hand-worked vectors
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         in_valid = 1'b1; op = T_OP[i]; opa_lo = T_LO[i]; opa_hi = T_HI[i];
         amt_reg = T_AMT[i]; imm_sel = 1'b0; amt_imm = 5'd17;
         #1;
         chk("R2 R3 R4 R5 table", result, T_EXP[i]);
         @(posedge clk);
      end
      // last shift in table (i=6) left carry=1, zf=1; op 11 must not change that
      #1;
      chk("R9 reserved op keeps flags", {28'b0, cy, ov, sgn, zf}, 32'h9);
      mflags = 4'b1001;

      // funnel must leave flags alone even when its result would differ
      run(2'b10, 32'h0, 32'h80000001, 32'd0, 5'd0, 1'b0, "R9 R5 funnel");

      // flags ignore non-valid cycles
      @(negedge clk);
      in_valid = 1'b0; op = 2'b01; opa_lo = 32'h40000000; amt_reg = 32'd1;
      @(posedge clk); #1;
      chk("R10 no update when idle", {28'b0, cy, ov, sgn, zf}, {28'b0, mflags});
      chk("R11 flag_we idle", {31'b0, flag_we}, 32'b0);

      // R1: unused amount source carries distracting values
      run(2'b01, 32'h00000003, 32'h0, 32'hFFFFFFE3, 5'd9, 1'b0, "R1 reg source");
      run(2'b00, 32'h80000010, 32'h0, 32'h0000001D, 5'd4, 1'b1, "R1 imm source");
      run(2'b10, 32'hF0000000, 32'h0000000F, 32'd7, 5'd4, 1'b1, "R1 R4 imm funnel");

      // sweeps over all distances with random operands
      for (int n = 0; n < 32; n++) begin
         a = $urandom; b = $urandom; junk = $urandom;
         run(2'b00, a | 32'h80000000, b, {junk[31:5], 5'(n)}, 5'(~n), 1'b0, "R2 R6 sweep");
         a = $urandom; b = $urandom; junk = $urandom;
         run(2'b01, a, b, junk, 5'(n), 1'b1, "R3 R6 sweep");
         a = $urandom; b = $urandom; junk = $urandom;
         run(2'b10, a, b, {junk[31:5], 5'(n)}, 5'(n + 3), 1'b0, "R4 sweep");
         a = $urandom; b = $urandom;
         run(2'b11, a, b, 32'(n), 5'(n), 1'b0, "R9 reserved sweep");
      end

      // zero-amount carry and zero flag corners
      run(2'b00, 32'hFFFFFFFF, 32'h0, 32'd0, 5'd0, 1'b0, "R6 zero distance sra");
      run(2'b01, 32'h00000001, 32'h0, 32'd0, 5'd0, 1'b1, "R6 zero distance sll");
      run(2'b00, 32'h00000001, 32'h0, 32'd1, 5'd0, 1'b0, "R8 zero result sra");
      run(2'b00, 32'h80000000, 32'h0, 32'd31, 5'd0, 1'b0, "R2 full sign fill");

      // reset clears flags after activity
      run(2'b01, 32'hFFFFFFFF, 32'h0, 32'd4, 5'd0, 1'b0, "R8 set sign");
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      chk("R10 async reset", {28'b0, cy, ov, sgn, zf}, 32'b0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule